// File: doc/BRIEF.md
# Smart Card Bit Clock Generator

This block derives all timing for a contact smart card serial link from the chip's system clock. The first stage is a prescaler. A 2-bit range code sets its divide ratio to 1, 4, 16 or 64. Its enable pulses feed an 8-bit reload divider. Each time that divider expires, a card clock flip-flop toggles, so the card clock always has a 50% duty cycle. When enabled, the card clock is sent out on a clock pin for the card.

A second counter counts completed card clock cycles. The number of cycles that make up one elementary time unit (one bit) is picked by a separate 2-bit code, and one of its settings is not a power of two. At the end of each bit the counter emits a one-system-clock bit-boundary strobe. Halfway through the bit it emits a sample strobe. A transmitter or receiver can use these strobes directly.

Software or a framing engine restarts all timing by pulsing a synchronous restart input. Any change of the divider value, the range code or the bit-length code restarts the timing in the same way. The resulting bit rate is f_sys / (2 · 4^n · (N+1) · S).

Top module: `sc_bitclk_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sck_out`, `bit_strobe` and `sample_strobe` are all 0.
- R2: The range code `range_sel` selects n (00→0, 01→1, 10→2, 11→3). After a restart the internal card clock is low. It then toggles every 4^n · (`div_val`+1) system clocks.
- R3: With `sck_oe` = 1, `sck_out` equals the internal card clock. With `sck_oe` = 0, `sck_out` is held low for as long as the enable stays low.
- R4: `etu_sel` selects S cards clocks per bit (00→32, 01→64, 10→372, 11→256). `bit_strobe` pulses for exactly one system clock once every 2 · 4^n · (N+1) · S system clocks.
- R5: Let a restart be taken at clock edge E0. The first `bit_strobe` is high after edge E0 + 2·S·4^n·(N+1).
- R6: `sample_strobe` pulses for one system clock once per bit. Its first pulse is high after edge E0 + S·4^n·(N+1), which is midway through the bit.
- R7: A `restart` sampled high clears all counters and the card clock. No strobe is high in the following cycle, even if a strobe was due at that edge.
- R8: A change of `div_val`, `range_sel` or `etu_sel` has the same effect as a restart at the edge where the new value is first sampled.
- R9: `bit_strobe` and `sample_strobe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous timing restart |
| div_val | input | 8 | Reload value N of the card clock divider |
| range_sel | input | 2 | Prescaler range code n |
| etu_sel | input | 2 | Bit length code (cards clocks per bit) |
| sck_oe | input | 1 | Card clock output enable |
| sck_out | output | 1 | Card clock pin, low when disabled |
| bit_strobe | output | 1 | One-cycle pulse at each bit boundary |
| sample_strobe | output | 1 | One-cycle pulse at mid-bit |

## Verification
Two events can land on the same clock edge: a restart and the bit boundary that the running count was about to reach. The bench counts system clocks from a restart and asserts `restart` again in the cycle just before the boundary edge. It then requires `bit_strobe` to stay low at that edge and the next boundary to arrive one full bit period later, measured from that edge. A configuration change made mid-bit is judged the same way: its first strobe time is measured against the new settings.

// File: rtl/sc_bitclk_pkg.sv
// Package: shared widths and decode helpers for the smart card bit clock
// generator. Assumes a 2-bit range code and a 2-bit bit-length code.
package sc_bitclk_pkg;

    localparam int DIV_W     = 8;
    localparam int RANGE_W   = 2;
    localparam int ETU_SEL_W = 2;
    localparam int ETU_W     = 9;
    localparam int PRE_W     = 2 * ((1 << RANGE_W) - 1);

    // Configuration fields whose change forces a timing restart.
    typedef struct packed {
        logic [DIV_W-1:0]     div;
        logic [RANGE_W-1:0]   range;
        logic [ETU_SEL_W-1:0] etu;
    } sc_cfg_t;

    // Decode the bit-length code into card clock cycles per bit.
    function automatic logic [ETU_W-1:0] etu_cycles(input logic [ETU_SEL_W-1:0] sel);
        logic [ETU_W-1:0] len;
        case (sel)
            2'b00:   len = ETU_W'(32);
            2'b01:   len = ETU_W'(64);
            2'b10:   len = ETU_W'(372);
            default: len = ETU_W'(256);
        endcase
        return len;
    endfunction

endpackage

// File: rtl/sc_prescaler.sv
// Module: power-of-four prescaler. It emits an enable every 4^range system
// clocks. Assumes that clear and range changes restart the count from zero.
module sc_prescaler #(
    parameter int RANGE_W = 2,
    parameter int PRE_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [RANGE_W-1:0] range,
    output logic               pre_en
);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] term;

    // Terminal count is 4^range - 1, a run of 2*range ones.
    always_comb begin
        term = PRE_W'((32'd1 << (2 * int'(range))) - 32'd1);
    end

    assign pre_en = (cnt == term);

    // Count system clocks and wrap at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (pre_en) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sc_reload_div.sv
// Module: reload divider. It counts prescaler enables and fires a one-cycle
// tick on every (reload+1)-th enable. Assumes a reload value that stays
// stable between clears.
module sc_reload_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == reload);

    // Advance on each enable and wrap at the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sc_etu_counter.sv
// Module: bit period counter. It counts completed card clock cycles and
// emits registered bit-boundary and mid-bit strobes. Assumes an even
// length of at least 2.
module sc_etu_counter #(
    parameter int ETU_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             cyc_done,
    input  logic [ETU_W-1:0] len,
    output logic             bit_stb,
    output logic             smp_stb
);

    logic [ETU_W-1:0] cnt;
    logic [ETU_W-1:0] last_idx;
    logic [ETU_W-1:0] mid_idx;
    logic             at_last;
    logic             at_mid;

    // Derive the index of the last cycle and of the mid-bit cycle.
    always_comb begin
        last_idx = len - 1'b1;
        mid_idx  = (len >> 1) - 1'b1;
        at_last  = cyc_done && (cnt == last_idx);
        at_mid   = cyc_done && (cnt == mid_idx);
    end

    // Count card clock cycles within the bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (at_last) begin
            cnt <= '0;
        end else if (cyc_done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Register the strobes so that each lasts one system clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bit_stb <= 1'b0;
            smp_stb <= 1'b0;
        end else begin
            bit_stb <= at_last;
            smp_stb <= at_mid;
        end
    end

endmodule

// File: rtl/sc_bitclk_gen.sv
// Module: smart card bit clock generator (top). It chains the prescaler and
// the reload divider into a 50% duty card clock, drives that clock on a pin
// when enabled, and counts card cycles per bit to produce bit-boundary and
// mid-bit strobes. Assumes that all inputs are synchronous to clk.
module sc_bitclk_gen
    import sc_bitclk_pkg::*;
#(
    parameter int DIV_WIDTH   = DIV_W,
    parameter int RANGE_WIDTH = RANGE_W,
    parameter int ESEL_WIDTH  = ETU_SEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   restart,
    input  logic [DIV_WIDTH-1:0]   div_val,
    input  logic [RANGE_WIDTH-1:0] range_sel,
    input  logic [ESEL_WIDTH-1:0]  etu_sel,
    input  logic                   sck_oe,
    output logic                   sck_out,
    output logic                   bit_strobe,
    output logic                   sample_strobe
);

    localparam int PRE_WIDTH = 2 * ((1 << RANGE_WIDTH) - 1);
    localparam int CFG_W     = DIV_WIDTH + RANGE_WIDTH + ESEL_WIDTH;

    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_changed;
    logic             clear;
    logic             pre_en;
    logic             half_tick;
    logic             card_ck;
    logic             card_ck_nxt;
    logic             cyc_done;
    logic [ETU_W-1:0] etu_len;
    logic             sck_q;

    assign cfg_now     = {div_val, range_sel, etu_sel};
    assign cfg_changed = (cfg_now != cfg_q);
    assign clear       = restart || cfg_changed;

    // Remember the configuration in force so that edits can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= cfg_now;
        end else begin
            cfg_q <= cfg_now;
        end
    end

    sc_prescaler #(
        .RANGE_W (RANGE_WIDTH),
        .PRE_W   (PRE_WIDTH)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .range  (range_sel),
        .pre_en (pre_en)
    );

    sc_reload_div #(
        .DIV_W (DIV_WIDTH)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .en     (pre_en),
        .reload (div_val),
        .tick   (half_tick)
    );

    // Next card clock level; a full cycle ends on the high-to-low toggle.
    always_comb begin
        card_ck_nxt = half_tick ? ~card_ck : card_ck;
        cyc_done    = half_tick && card_ck;
    end

    // Toggle the card clock on each half-period tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            card_ck <= 1'b0;
        end else begin
            card_ck <= card_ck_nxt;
        end
    end

    // Drive the pin register, forced low while output is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sck_q <= 1'b0;
        end else begin
            sck_q <= sck_oe && card_ck_nxt;
        end
    end

    assign sck_out = sck_q;
    assign etu_len = etu_cycles(etu_sel);

    sc_etu_counter #(
        .ETU_W (ETU_W)
    ) u_etu (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .cyc_done (cyc_done),
        .len      (etu_len),
        .bit_stb  (bit_strobe),
        .smp_stb  (sample_strobe)
    );

endmodule

// File: rtl/sc_bitclk_gen_checker.sv
// Module: property checker for sc_bitclk_gen, attached by bind. It watches
// only the ports of the top module.
module sc_bitclk_gen_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       restart,
    input logic [7:0] div_val,
    input logic [1:0] range_sel,
    input logic [1:0] etu_sel,
    input logic       sck_oe,
    input logic       sck_out,
    input logic       bit_strobe,
    input logic       sample_strobe
);

    logic [11:0] cfg_seen;
    logic        cfg_edit;

    // Track the configuration sampled at the previous edge.
    always_ff @(posedge clk) begin
        cfg_seen <= {div_val, range_sel, etu_sel};
    end

    assign cfg_edit = ({div_val, range_sel, etu_sel} != cfg_seen);

    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_strobe, sample_strobe}));

    assert_restart_quiets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!bit_strobe && !sample_strobe && !sck_out));

    assert_cfg_edit_quiets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_edit |=> (!bit_strobe && !sample_strobe));

    assert_pin_low_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_oe |=> !sck_out);

    assert_bit_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |=> !bit_strobe);

    assert_sample_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);

endmodule

bind sc_bitclk_gen sc_bitclk_gen_checker u_sc_bitclk_gen_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart       (restart),
    .div_val       (div_val),
    .range_sel     (range_sel),
    .etu_sel       (etu_sel),
    .sck_oe        (sck_oe),
    .sck_out       (sck_out),
    .bit_strobe    (bit_strobe),
    .sample_strobe (sample_strobe)
);

// File: tb/sc_bitclk_gen_bench.sv
// Bench: directed scenarios for sc_bitclk_gen. Each task checks its own
// results, and all timing is counted from the edge where a restart is taken.
module sc_bitclk_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic [7:0] div_val = 8'd0;
    logic [1:0] range_sel = 2'd0;
    logic [1:0] etu_sel = 2'd0;
    logic       sck_oe = 1'b0;
    logic       sck_out;
    logic       bit_strobe;
    logic       sample_strobe;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    sc_bitclk_gen u_sc_bitclk_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .restart       (restart),
        .div_val       (div_val),
        .range_sel     (range_sel),
        .etu_sel       (etu_sel),
        .sck_oe        (sck_oe),
        .sck_out       (sck_out),
        .bit_strobe    (bit_strobe),
        .sample_strobe (sample_strobe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int s_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 32;
            2'b01:   return 64;
            2'b10:   return 372;
            default: return 256;
        endcase
    endfunction

    function automatic int half_of(input logic [1:0] rng, input logic [7:0] dv);
        return (1 << (2 * int'(rng))) * (int'(dv) + 1);
    endfunction

    // Apply settings and pulse restart; returns after the restart edge E0.
    task automatic start(input logic [1:0] rng, input logic [7:0] dv,
                         input logic [1:0] es, input logic oe);
        @(negedge clk);
        range_sel = rng;
        div_val   = dv;
        etu_sel   = es;
        sck_oe    = oe;
        restart   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
        @(posedge clk);
    endtask

    // Watch two bit periods after E0 (count k is sampled after edge Ek).
    task automatic measure(input string tag, input int h, input int s, input logic oe);
        int first_bit = -1, second_bit = -1, first_smp = -1;
        int n_bit = 0, n_smp = 0, both = 0, sck_bad = 0;
        for (int k = 1; k <= 4 * s * h + 2; k++) begin
            @(negedge clk);
            if (bit_strobe) begin
                n_bit++;
                if (first_bit < 0) first_bit = k;
                else if (second_bit < 0) second_bit = k;
            end
            if (sample_strobe) begin
                n_smp++;
                if (first_smp < 0) first_smp = k;
            end
            if (bit_strobe && sample_strobe) both++;
            if (oe) begin
                if (sck_out !== logic'(((k / h) % 2) == 1)) sck_bad++;
            end else if (sck_out !== 1'b0) begin
                sck_bad++;
            end
            if (k < 4 * s * h + 2) @(posedge clk);
        end
        check("R5", {tag, " first bit strobe"}, first_bit, 2 * s * h);
        check("R4", {tag, " bit period"}, second_bit - first_bit, 2 * s * h);
        check("R4", {tag, " bit strobe count"}, n_bit, 2);
        check("R6", {tag, " first sample strobe"}, first_smp, s * h);
        check("R6", {tag, " sample strobe count"}, n_smp, 2);
        check("R9", {tag, " coincident strobes"}, both, 0);
        check(oe ? "R2" : "R3", {tag, " card clock pin mismatches"}, sck_bad, 0);
    endtask

    task automatic test_reset;
        @(negedge clk);
        check("R1", "sck_out in reset", int'(sck_out), 0);
        check("R1", "bit_strobe in reset", int'(bit_strobe), 0);
        check("R1", "sample_strobe in reset", int'(sample_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "strobes after release", int'(bit_strobe | sample_strobe | sck_out), 0);
    endtask

    task automatic test_rates;
        start(2'd0, 8'd0, 2'd2, 1'b1);
        measure("n0 N0 S372", half_of(2'd0, 8'd0), s_of(2'd2), 1'b1);
        start(2'd1, 8'd2, 2'd0, 1'b1);
        measure("n1 N2 S32", half_of(2'd1, 8'd2), s_of(2'd0), 1'b1);
        start(2'd2, 8'd1, 2'd1, 1'b1);
        measure("n2 N1 S64", half_of(2'd2, 8'd1), s_of(2'd1), 1'b1);
        start(2'd3, 8'd0, 2'd0, 1'b1);
        measure("n3 N0 S32", half_of(2'd3, 8'd0), s_of(2'd0), 1'b1);
        start(2'd0, 8'd3, 2'd3, 1'b1);
        measure("n0 N3 S256", half_of(2'd0, 8'd3), s_of(2'd3), 1'b1);
    endtask

    task automatic test_pin_off;
        start(2'd1, 8'd0, 2'd0, 1'b0);
        measure("pin off R3", half_of(2'd1, 8'd0), s_of(2'd0), 1'b0);
    endtask

    // Restart in the cycle before a due boundary: restart wins (R7).
    task automatic test_restart_collision;
        int h = half_of(2'd0, 8'd1);
        int s = s_of(2'd0);
        int seen = 0;
        start(2'd0, 8'd1, 2'd0, 1'b1);
        for (int k = 1; k < 2 * s * h; k++) begin
            @(negedge clk);
            if (bit_strobe) seen++;
        end
        restart = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
        check("R7", "strobe at restart edge", int'(bit_strobe | sample_strobe), 0);
        check("R7", "early strobes before collision", seen, 0);
        measure("after collision R7", h, s, 1'b1);
    endtask

    // Change the divider mid-bit: timing restarts with the new value (R8).
    task automatic test_cfg_change;
        start(2'd0, 8'd0, 2'd0, 1'b1);
        repeat (20) @(posedge clk);
        @(negedge clk);
        div_val = 8'd2;
        @(posedge clk);
        @(negedge clk);
        check("R8", "strobes at edit edge", int'(bit_strobe | sample_strobe | sck_out), 0);
        @(posedge clk);
        measure("after edit R8", half_of(2'd0, 8'd2), s_of(2'd0), 1'b1);
    endtask

    initial begin
        #(5.0 * 190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        test_rates();
        test_pin_off();
        test_restart_collision();
        test_cfg_change();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule